// File: doc/BRIEF.md
# Dual Configurable Decade Divider

This block holds two decades. Each decade has a divide-by-2 section and a divide-by-5 section, and each section has its own count input. A section advances once for each falling edge on its count input. A two-bit mode selects how the sections of a decade are linked. In BCD order the divide-by-2 output feeds the divide-by-5 section. In bi-quinary order the top bit of the divide-by-5 section feeds the divide-by-2 section. In split mode the two sections run on their own. A cascade control can feed decade 1 from a chosen output of decade 0. With these settings one instance divides an input by 2, 4, 5, 10, 20, 25, 50 or 100.

All state runs on one system clock. Each count input passes through a two-flop synchroniser followed by a falling-edge detector. A link between sections inside a decade, and the link from decade 0 to decade 1, act in the same clock cycle as the edge that causes them. The chain therefore behaves like a ripple counter with no delay. Each decade has an active-high asynchronous clear. The block has no data stream, so every pin is a plain control or status pin and there is no valid/ready handshake.

Top module: `dual_decade_divider`

## Requirements
- R1: A falling edge on a count input shows on the outputs within three system-clock cycles of the first clock edge that samples the input low. A rising edge has no effect.
- R2: Each decade output is {Q3,Q2,Q1,Q0}. Q0 is the divide-by-2 bit and toggles on each advance. Q3:Q1 is the divide-by-5 count and steps 0,1,2,3,4,0 in binary.
- R3: Mode 2'b00 (BCD): each fall of Q0 advances the divide-by-5 section, so the 4-bit output counts 0 to 9 and then wraps to 0. The decade's divide-by-5 count input is ignored.
- R4: Mode 2'b01 (bi-quinary): the divide-by-5 count input drives that section, and the wrap of Q3:Q1 from 4 to 0 (Q3 falling) toggles Q0. Q0 is then high for exactly 5 of every 10 input edges. The divide-by-2 count input is ignored.
- R5: Mode 2'b10 or 2'b11 (split): the two sections count independently, each from its own count input.
- R6: A high level on a decade's clear forces its four outputs to 0 at once, without a clock. While the clear stays high, edges for that decade are ignored. After release, counting restarts from 0 on the next falling edge.
- R7: The two clears are independent. A clear on one decade leaves the other decade's count unchanged, and both together zero all 8 bits.
- R8: When cascade_en is 1, decade 1 ignores its own count inputs. Instead, every count input that decade 1 takes from outside in its mode receives the falling edge of dec0_q[0] (cascade_tap=0) or of dec0_q[3] (cascade_tap=1).
- R9: A linked advance, inside a decade or across the cascade, happens in the same clock cycle as the edge that triggers it. Each output therefore changes at most once per advance, by exactly one count step.
- R10: Decade 0 in BCD mode cascaded from dec0_q[3] into decade 1 in BCD mode divides by 100: after 100 edges both decades read 0, and after 50 edges decade 1 reads 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cnt_a_in | input | 2 | Divide-by-2 count input, one bit per decade |
| cnt_b_in | input | 2 | Divide-by-5 count input, one bit per decade |
| dec_clr | input | 2 | Asynchronous active-high clear, one bit per decade |
| dec0_mode | input | 2 | Decade 0 linkage: 00 BCD, 01 bi-quinary, 1x split |
| dec1_mode | input | 2 | Decade 1 linkage: 00 BCD, 01 bi-quinary, 1x split |
| cascade_en | input | 1 | Feed decade 1 from decade 0 instead of its own inputs |
| cascade_tap | input | 1 | Cascade source: 0 selects dec0_q[0], 1 selects dec0_q[3] |
| dec0_q | output | 4 | Decade 0 outputs {Q3,Q2,Q1,Q0} |
| dec1_q | output | 4 | Decade 1 outputs {Q3,Q2,Q1,Q0} |

## Verification
The step properties assume three things: the mode of a decade stays the same across the cycle in which it is checked, a clear is held for at least one full clock cycle, and clears change away from the clock edge. The bench always changes modes and clears at the falling clock edge, holds a clear for several cycles, and releases it only after the count inputs have been low long enough for the synchroniser to settle. Count pulses are kept at four cycles high and four cycles low, so each edge reaches the outputs before the bench samples them. The random phase draws modes, cascade settings, clears and sets of simultaneous input pulses from a fixed seed. The directed phase covers wrap points, the divide-by-100 chain and the bi-quinary duty cycle.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  localparam int unsigned DIV_LO    = 2;
  localparam int unsigned DIV_HI    = 5;
  localparam int unsigned HI_W      = $clog2(DIV_HI);
  localparam int unsigned Q_W       = 1 + HI_W;
  localparam int unsigned SYNC_LEN  = 2;

  typedef enum logic [1:0] {
    LINK_BCD   = 2'b00,
    LINK_BIQ   = 2'b01,
    LINK_SPLIT = 2'b10,
    LINK_ALT   = 2'b11
  } link_mode_e;

  typedef struct packed {
    logic adv_lo;
    logic adv_hi;
  } sect_adv_t;
endpackage

// File: rtl/ddc_edge_sync.sv
module ddc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);
  localparam int unsigned LEN = STAGES + 1;

  logic [LEN-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= {pipe_q[LEN-2:0], pin_i};
    end
  end

  // previous synchronised sample high, current low
  assign fall_o = pipe_q[LEN-1] & ~pipe_q[LEN-2];
endmodule

// File: rtl/ddc_mod_counter.sv
module ddc_mod_counter #(
  parameter int unsigned MOD = 5,
  localparam int unsigned W  = (MOD > 2) ? $clog2(MOD) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         adv_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  logic         arst_n;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nxt;

  assign arst_n = rst_n & ~clr_i;

  generate
    if (MOD == 2) begin : g_toggle
      assign cnt_nxt = ~cnt_q;
    end else begin : g_mod
      assign cnt_nxt = (cnt_q == LAST) ? '0 : cnt_q + W'(1);
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
    end else if (adv_i) begin
      cnt_q <= cnt_nxt;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = adv_i & (cnt_q == LAST);
endmodule

// File: rtl/ddc_decade.sv
module ddc_decade
  import ddc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_i,
  input  logic [1:0]     mode_i,
  input  logic           ext_lo_i,
  input  logic           ext_hi_i,
  output logic [Q_W-1:0] q_o,
  output logic           fall_q0_o,
  output logic           fall_q3_o
);
  link_mode_e  mode;
  sect_adv_t   adv;
  logic        lo_cnt;
  logic [HI_W-1:0] hi_cnt;
  logic        lo_wrap;
  logic        hi_wrap;

  assign mode = link_mode_e'(mode_i);

  // zero-delay ripple: a linked section moves in the same cycle
  always_comb begin
    adv = '0;
    unique case (mode)
      LINK_BCD: begin
        adv.adv_lo = ext_lo_i;
        adv.adv_hi = lo_wrap;
      end
      LINK_BIQ: begin
        adv.adv_hi = ext_hi_i;
        adv.adv_lo = hi_wrap;
      end
      default: begin
        adv.adv_lo = ext_lo_i;
        adv.adv_hi = ext_hi_i;
      end
    endcase
  end

  ddc_mod_counter #(.MOD(DIV_LO)) u_lo (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr_i),
    .adv_i  (adv.adv_lo),
    .cnt_o  (lo_cnt),
    .wrap_o (lo_wrap)
  );

  ddc_mod_counter #(.MOD(DIV_HI)) u_hi (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr_i),
    .adv_i  (adv.adv_hi),
    .cnt_o  (hi_cnt),
    .wrap_o (hi_wrap)
  );

  assign q_o       = {hi_cnt, lo_cnt};
  assign fall_q0_o = lo_wrap & ~clr_i;
  assign fall_q3_o = hi_wrap & ~clr_i;
endmodule

// File: rtl/dual_decade_divider.sv
module dual_decade_divider
  import ddc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cnt_a_in,
  input  logic [1:0] cnt_b_in,
  input  logic [1:0] dec_clr,
  input  logic [1:0] dec0_mode,
  input  logic [1:0] dec1_mode,
  input  logic       cascade_en,
  input  logic       cascade_tap,
  output logic [3:0] dec0_q,
  output logic [3:0] dec1_q
);
  localparam int unsigned NDEC = 2;

  logic [NDEC-1:0] fall_a;
  logic [NDEC-1:0] fall_b;
  logic [NDEC-1:0] ext_lo;
  logic [NDEC-1:0] ext_hi;
  logic [NDEC-1:0] f_q0;
  logic [NDEC-1:0] f_q3;
  logic [NDEC-1:0][1:0]     mode_arr;
  logic [NDEC-1:0][Q_W-1:0] q_arr;
  logic casc_edge;

  assign mode_arr[0] = dec0_mode;
  assign mode_arr[1] = dec1_mode;

  generate
    for (genvar d = 0; d < NDEC; d++) begin : g_sync
      ddc_edge_sync #(.STAGES(SYNC_LEN)) u_sa (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (cnt_a_in[d]),
        .fall_o (fall_a[d])
      );
      ddc_edge_sync #(.STAGES(SYNC_LEN)) u_sb (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (cnt_b_in[d]),
        .fall_o (fall_b[d])
      );
    end
  endgenerate

  assign casc_edge = cascade_tap ? f_q3[0] : f_q0[0];

  assign ext_lo[0] = fall_a[0];
  assign ext_hi[0] = fall_b[0];
  assign ext_lo[1] = cascade_en ? casc_edge : fall_a[1];
  assign ext_hi[1] = cascade_en ? casc_edge : fall_b[1];

  generate
    for (genvar d = 0; d < NDEC; d++) begin : g_dec
      ddc_decade u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (dec_clr[d]),
        .mode_i    (mode_arr[d]),
        .ext_lo_i  (ext_lo[d]),
        .ext_hi_i  (ext_hi[d]),
        .q_o       (q_arr[d]),
        .fall_q0_o (f_q0[d]),
        .fall_q3_o (f_q3[d])
      );
    end
  endgenerate

  assign dec0_q = q_arr[0];
  assign dec1_q = q_arr[1];
endmodule

// File: rtl/ddc_checker.sv
module ddc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] dec_clr,
  input logic [1:0] dec0_mode,
  input logic [1:0] dec1_mode,
  input logic [3:0] dec0_q,
  input logic [3:0] dec1_q
);
  logic [1:0][1:0] md;
  logic [1:0][3:0] qq;
  assign md[0] = dec0_mode;
  assign md[1] = dec1_mode;
  assign qq[0] = dec0_q;
  assign qq[1] = dec1_q;

  for (genvar d = 0; d < 2; d++) begin : g_chk
    AST_QUINARY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      qq[d][3:1] <= 3'd4); // R2

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      dec_clr[d] |-> (qq[d] == 4'd0)); // R6

    AST_BCD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (md[d] == 2'b00 && $past(md[d]) == 2'b00 && !dec_clr[d] && !$past(dec_clr[d])
       && !$stable(qq[d]))
      |-> (qq[d] == (($past(qq[d]) == 4'd9) ? 4'd0 : $past(qq[d]) + 4'd1))); // R3

    AST_BIQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (md[d] == 2'b01 && $past(md[d]) == 2'b01 && !dec_clr[d] && !$past(dec_clr[d])
       && !$stable(qq[d]))
      |-> (qq[d][3:1] == (($past(qq[d][3:1]) == 3'd4) ? 3'd0 : $past(qq[d][3:1]) + 3'd1)
           && qq[d][0] == ($past(qq[d][0]) ^ ($past(qq[d][3:1]) == 3'd4)))); // R4

    AST_SPLIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (md[d][1] && $past(md[d][1]) && !dec_clr[d] && !$past(dec_clr[d])
       && !$stable(qq[d][3:1]))
      |-> (qq[d][3:1] == (($past(qq[d][3:1]) == 3'd4) ? 3'd0 : $past(qq[d][3:1]) + 3'd1))); // R5
  end
endmodule

bind dual_decade_divider ddc_checker u_ddc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .dec_clr   (dec_clr),
  .dec0_mode (dec0_mode),
  .dec1_mode (dec1_mode),
  .dec0_q    (dec0_q),
  .dec1_q    (dec1_q)
);

// File: tb/dual_decade_divider_tb_top.sv
module dual_decade_divider_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] cnt_a_in, cnt_b_in, dec_clr, dec0_mode, dec1_mode;
  logic       cascade_en, cascade_tap;
  logic [3:0] dec0_q, dec1_q;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  logic [3:0] m_q [2];

  always #2 clk = ~clk;

  dual_decade_divider dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_a_in(cnt_a_in), .cnt_b_in(cnt_b_in),
    .dec_clr(dec_clr), .dec0_mode(dec0_mode), .dec1_mode(dec1_mode),
    .cascade_en(cascade_en), .cascade_tap(cascade_tap),
    .dec0_q(dec0_q), .dec1_q(dec1_q)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      finish_run();
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // returns {fall_q3, fall_q0, next_q}
  function automatic logic [5:0] step(input logic [3:0] q, input logic [1:0] mode,
                                      input logic ea, input logic eb);
    logic a2, a5;
    logic [2:0] hi;
    hi = q[3:1];
    if (mode == 2'b00) begin a2 = ea; a5 = ea & q[0]; end
    else if (mode == 2'b01) begin a5 = eb; a2 = eb & (hi == 3'd4); end
    else begin a2 = ea; a5 = eb; end
    step[3:0] = {a5 ? ((hi == 3'd4) ? 3'd0 : hi + 3'd1) : hi, q[0] ^ a2};
    step[4]   = a2 & q[0];
    step[5]   = a5 & (hi == 3'd4);
  endfunction

  task automatic model(input logic [1:0] ea, input logic [1:0] eb);
    logic [5:0] r0, r1;
    logic ce;
    r0 = step(m_q[0], dec0_mode, ea[0], eb[0]);
    if (dec_clr[0]) r0 = 6'd0;
    ce = cascade_tap ? r0[5] : r0[4];
    r1 = cascade_en ? step(m_q[1], dec1_mode, ce, ce) : step(m_q[1], dec1_mode, ea[1], eb[1]);
    if (dec_clr[1]) r1 = 6'd0;
    m_q[0] = r0[3:0];
    m_q[1] = r1[3:0];
  endtask

  task automatic pulse(input logic [1:0] a, input logic [1:0] b, input string req);
    cnt_a_in = a; cnt_b_in = b;
    tick(4);
    chk({req, " rise"}, dec0_q, m_q[0]);
    cnt_a_in = 2'b00; cnt_b_in = 2'b00;
    tick(4);
    model(a, b);
    chk({req, " d0"}, dec0_q, m_q[0]);
    chk({req, " d1"}, dec1_q, m_q[1]);
  endtask

  task automatic set_clr(input logic [1:0] c);
    dec_clr = c;
    tick(2);
    if (c[0]) m_q[0] = 4'd0;
    if (c[1]) m_q[1] = 4'd0;
  endtask

  initial begin
    int seed;
    int hi_cnt;
    seed = $urandom(32'd5150);
    rst_n = 1'b0; cnt_a_in = '0; cnt_b_in = '0; dec_clr = '0;
    dec0_mode = 2'b00; dec1_mode = 2'b00; cascade_en = 1'b0; cascade_tap = 1'b0;
    m_q[0] = '0; m_q[1] = '0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk("reset d0", dec0_q, 4'd0);
    chk("reset d1", dec1_q, 4'd0);

    // R1: rising edge alone has no effect, fall lands within 3 cycles
    cnt_a_in = 2'b01;
    tick(4);
    chk("R1 rise ignored", dec0_q, 4'd0);
    cnt_a_in = 2'b00;
    tick(3);
    chk("R1 fall latency", dec0_q, 4'd1);
    tick(1);
    m_q[0] = 4'd1;

    // R3: BCD wrap through 9, divide-by-5 input ignored
    for (int i = 0; i < 9; i++) pulse(2'b01, 2'b00, "R3 bcd");
    chk("R3 wrap to 0", dec0_q, 4'd0);
    pulse(2'b00, 2'b01, "R3 b ignored");
    chk("R3 b ignored value", dec0_q, 4'd0);

    // R4: bi-quinary duty cycle, divide-by-2 input ignored
    dec0_mode = 2'b01;
    set_clr(2'b01); set_clr(2'b00);
    hi_cnt = 0;
    for (int i = 0; i < 10; i++) begin
      pulse(2'b00, 2'b01, "R4 biq");
      if (dec0_q[0]) hi_cnt++;
    end
    chk("R4 duty high count", 4'(hi_cnt), 4'd5);
    pulse(2'b01, 2'b00, "R4 a ignored");
    chk("R4 a ignored value", dec0_q, 4'd0);

    // R5 and R2: split sections
    dec0_mode = 2'b10;
    for (int i = 0; i < 6; i++) pulse(2'b00, 2'b01, "R2 quinary seq");
    chk("R2 quinary after 6", dec0_q, 4'b0010);
    pulse(2'b01, 2'b00, "R5 split lo");
    chk("R5 split lo only", dec0_q, 4'b0011);

    // R6 and R7: clear ignores edges, other decade untouched
    dec1_mode = 2'b10;
    pulse(2'b10, 2'b10, "R7 d1 load");
    set_clr(2'b01);
    chk("R6 cleared", dec0_q, 4'd0);
    pulse(2'b11, 2'b11, "R6 edges in clear");
    chk("R6 held zero", dec0_q, 4'd0);
    chk("R7 other decade kept", dec1_q, m_q[1]);
    set_clr(2'b00);
    chk("R6 still zero after release", dec0_q, 4'd0);
    pulse(2'b01, 2'b00, "R6 resume");
    chk("R6 resume from zero", dec0_q, 4'd1);
    set_clr(2'b11);
    chk("R7 both zero d0", dec0_q, 4'd0);
    chk("R7 both zero d1", dec1_q, 4'd0);
    set_clr(2'b00);

    // R10 and R8: divide by 100 via cascade from Q3
    dec0_mode = 2'b00; dec1_mode = 2'b00; cascade_en = 1'b1; cascade_tap = 1'b1;
    for (int i = 0; i < 50; i++) pulse(2'b11, 2'b10, "R8 cascade");
    chk("R10 half way d1", dec1_q, 4'd5);
    for (int i = 0; i < 50; i++) pulse(2'b01, 2'b00, "R10 cascade");
    chk("R10 full d0", dec0_q, 4'd0);
    chk("R10 full d1", dec1_q, 4'd0);

    // R9 and random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 4'd0) begin
        dec0_mode = r[5:4]; dec1_mode = r[7:6];
        cascade_en = r[8]; cascade_tap = r[9];
      end
      if (r[14:12] == 3'd0) begin
        set_clr(r[11:10]);
        pulse(r[17:16], r[19:18], "R6 random clear");
        set_clr(2'b00);
      end else begin
        pulse(r[17:16], r[19:18], "R9 random");
      end
    end

    finish_run();
  end
endmodule